// File: doc/BRIEF.md
# Descriptor Ring Pointer Tracker

This block keeps the hardware-side accounting for a circular queue of DMA descriptors. Software fills slots in memory and reports them in counted batches through a small register port. A processing engine is offered descriptors one at a time through a request/done handshake. Each finished descriptor moves from an "available" window into a "completed but not yet released" window. Software reads the size and start of that window, handles the finished slots, and hands them back with a release count. Descriptor fetch and the processing datapath live outside this block.

The ring length is programmable. Its upper limit depends on the descriptor format that is selected: large descriptors allow a shorter ring than small ones. Every index wraps from the last slot back to slot 0. The block leaves reset halted, and software must clear the stop bit before any descriptor is offered.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the available and pending counts and both ring indices are zero, the block is stopped, large-descriptor mode is selected, the stored ring size is RESET_SIZE, both error bits are clear and eng_req is low.
- R2: A write of N to the add register (address 2) adds to the available count and never replaces it. The count is readable in status (address 6) bits [14:0].
- R3: An add is clamped so that available plus pending never exceeds the effective ring size. The clamped count accepted is min(N, size − available − pending). When N exceeds that room, sticky status bit 17 is set.
- R4: eng_req is high exactly when the block is not stopped and the available count is nonzero. eng_idx gives the ring index of the next descriptor to consume.
- R5: A cycle with eng_done high while the available count is nonzero moves one descriptor from available to pending and advances eng_idx by one, wrapping from size−1 to 0. eng_done while the available count is zero changes nothing.
- R6: A write of N to the release register (address 3) lowers the pending count by min(N, pending) and advances the completed index by the same amount modulo the size. When N exceeds pending, sticky status bit 16 is set.
- R7: The done register (address 4) reports the pending count in bits [14:0] and the ring index of the oldest completed descriptor in bits starting at 16 (IDX_W bits wide).
- R8: Writing the stop register (address 5) with bit 0 = 1 halts consumption, so eng_req is low from the next cycle. Writing it with bit 0 = 0 enables consumption. Completions keep being counted while halted. Status bit 18 shows the stopped state.
- R9: The descriptor-format register (address 1) accepts 7 (large, ring cap CAP_LARGE) or 1 (small, ring cap CAP_SMALL) and reads back the code in force. Any other value is ignored. Status bit 19 is 1 in large mode.
- R10: A size write (address 0) stores the value clamped to the range 1..2^IDX_W. The effective size, read back at address 0, is the smaller of the stored value and the cap of the current format.
- R11: Size and format writes made while the block is running are ignored. When stopped, an accepted size or format write reinitialises both indices and both counts to zero but keeps the error bits.
- R12: When a completion and an add or release write fall in the same cycle, both take effect. The clamp and error judgements use the counts from before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| eng_req | output | 1 | Descriptor available for the engine |
| eng_idx | output | IDX_W | Ring index of the descriptor offered |
| eng_done | input | 1 | Engine finished the offered descriptor |

## Verification
A completion from the engine and a register write that moves one of the two counts can land on the same clock edge. The bench provokes this by pulsing eng_done in the same cycle as add and release writes across a sweep of ring sizes and batch values. It includes batches that overrun the room or the pending count, and sizes where either index wraps. A reference model in the bench judges every such cycle. It clamps against the counts from before the cycle, then applies the completion, and compares the available count, pending count, both indices and both error bits after the edge.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

   localparam int CNT_W  = 15;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_SIZE  = 3'd0,
      RA_DFMT  = 3'd1,
      RA_ADD   = 3'd2,
      RA_REL   = 3'd3,
      RA_DONE  = 3'd4,
      RA_STOP  = 3'd5,
      RA_STAT  = 3'd6,
      RA_NONE  = 3'd7
   } reg_addr_e;

   localparam logic [31:0] FMT_LARGE = 32'd7;
   localparam logic [31:0] FMT_SMALL = 32'd1;

   localparam int ST_RELERR = 16;
   localparam int ST_ADDERR = 17;
   localparam int ST_STOP   = 18;
   localparam int ST_LARGE  = 19;
   localparam int DONE_IDX_LSB = 16;

   function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int IDX_W = 13,
   parameter int SZ_W  = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SZ_W-1:0]  step,
   input  logic [SZ_W-1:0]  size,
   output logic [IDX_W-1:0] ptr
);

   logic [SZ_W:0] sum;
   logic [SZ_W:0] wrapped;

   always_comb begin
      sum     = {1'b0, SZ_W'(ptr)} + {1'b0, step};
      wrapped = (sum >= {1'b0, size}) ? (sum - {1'b0, size}) : sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (clr)    ptr <= '0;
      else if (adv)    ptr <= wrapped[IDX_W-1:0];
   end

   // R5 / R6: an index never leaves the ring
   a_r5_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      SZ_W'(ptr) < size);

endmodule

// File: rtl/ring_counts.sv
module ring_counts
   import desc_ring_pkg::*;
#(
   parameter int IDX_W = 13,
   parameter int SZ_W  = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SZ_W-1:0]  size,
   input  logic             add_we,
   input  logic [31:0]      add_n,
   input  logic             rel_we,
   input  logic [31:0]      rel_n,
   input  logic             done_in,
   output logic [CNT_W-1:0] avail,
   output logic [CNT_W-1:0] pend,
   output logic             add_err,
   output logic             rel_err,
   output logic             done_acc,
   output logic [SZ_W-1:0]  rel_step
);

   logic [31:0] room32, pend32;
   logic [31:0] add_acc32, rel_acc32;
   logic        add_over, rel_over;
   logic [CNT_W-1:0] avail_nx, pend_nx;

   always_comb begin
      pend32    = 32'(pend);
      room32    = 32'(size) - 32'(avail) - pend32;
      add_over  = add_we && (add_n > room32);
      rel_over  = rel_we && (rel_n > pend32);
      add_acc32 = add_we ? umin32(add_n, room32) : 32'd0;
      rel_acc32 = rel_we ? umin32(rel_n, pend32) : 32'd0;
      done_acc  = done_in && (avail != '0);
      avail_nx  = avail + add_acc32[CNT_W-1:0] - CNT_W'(done_acc);
      pend_nx   = pend + CNT_W'(done_acc) - rel_acc32[CNT_W-1:0];
      rel_step  = rel_acc32[SZ_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         avail <= '0;
         pend  <= '0;
      end else if (clr) begin
         avail <= '0;
         pend  <= '0;
      end else begin
         avail <= avail_nx;
         pend  <= pend_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         add_err <= 1'b0;
         rel_err <= 1'b0;
      end else begin
         if (add_over) add_err <= 1'b1;
         if (rel_over) rel_err <= 1'b1;
      end
   end

   // R3: occupancy never exceeds the ring
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(avail) + 32'(pend)) <= 32'(size));

   // R6: the release error is sticky
   a_r6_relerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rel_err |=> rel_err);

   // R3: the add error is sticky
   a_r3_adderr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      add_err |=> add_err);

   // R5: a completion with nothing available leaves the count at zero
   a_r5_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in && avail == '0 && !add_we && !clr) |=> (avail == '0));

   // R12: completion alongside an empty release still adds one pending
   a_r12_done_with_rel: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in && avail != '0 && rel_we && rel_n == 32'd0 && !clr)
         |=> (pend == $past(pend) + 1'b1));

endmodule

// File: rtl/ring_regs.sv
module ring_regs
   import desc_ring_pkg::*;
#(
   parameter int IDX_W      = 13,
   parameter int CAP_LARGE  = 4096,
   parameter int CAP_SMALL  = 8192,
   parameter int RESET_SIZE = 1024,
   parameter int SZ_W       = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [CNT_W-1:0]  avail,
   input  logic [CNT_W-1:0]  pend,
   input  logic              add_err,
   input  logic              rel_err,
   input  logic [IDX_W-1:0]  done_idx,
   output logic [31:0]       reg_rdata,
   output logic [SZ_W-1:0]   size_eff,
   output logic              stopped,
   output logic              clr,
   output logic              add_we,
   output logic              rel_we
);

   localparam int               RING_MAX = 2 ** IDX_W;
   localparam logic [SZ_W-1:0]  MAX_SZ   = SZ_W'(RING_MAX);
   localparam logic [SZ_W-1:0]  CAP_L    = SZ_W'(CAP_LARGE);
   localparam logic [SZ_W-1:0]  CAP_S    = SZ_W'(CAP_SMALL);

   reg_addr_e         ra;
   logic [SZ_W-1:0]   size_q, size_wr, cap;
   logic              large_q;
   logic              fmt_ok, size_hit, fmt_hit;

   assign ra = reg_addr_e'(reg_addr);

   always_comb begin
      fmt_ok   = (reg_wdata == FMT_LARGE) || (reg_wdata == FMT_SMALL);
      size_hit = reg_we && (ra == RA_SIZE) && stopped;
      fmt_hit  = reg_we && (ra == RA_DFMT) && stopped && fmt_ok;
      clr      = size_hit || fmt_hit;
      add_we   = reg_we && (ra == RA_ADD);
      rel_we   = reg_we && (ra == RA_REL);
      if (reg_wdata == 32'd0)                 size_wr = SZ_W'(1);
      else if (reg_wdata > 32'(RING_MAX))     size_wr = MAX_SZ;
      else                                    size_wr = reg_wdata[SZ_W-1:0];
   end

   generate
      if (CAP_LARGE == CAP_SMALL) begin : g_one_cap
         assign cap = CAP_L;
      end else begin : g_two_cap
         assign cap = large_q ? CAP_L : CAP_S;
      end
   endgenerate

   assign size_eff = (size_q > cap) ? cap : size_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q  <= SZ_W'(RESET_SIZE);
         large_q <= 1'b1;
         stopped <= 1'b1;
      end else begin
         if (size_hit) size_q  <= size_wr;
         if (fmt_hit)  large_q <= (reg_wdata == FMT_LARGE);
         if (reg_we && ra == RA_STOP) stopped <= reg_wdata[0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (ra)
         RA_SIZE: reg_rdata = 32'(size_eff);
         RA_DFMT: reg_rdata = large_q ? FMT_LARGE : FMT_SMALL;
         RA_DONE: begin
            reg_rdata[CNT_W-1:0]              = pend;
            reg_rdata[DONE_IDX_LSB +: IDX_W]  = done_idx;
         end
         RA_STOP: reg_rdata[0] = stopped;
         RA_STAT: begin
            reg_rdata[CNT_W-1:0] = avail;
            reg_rdata[ST_RELERR] = rel_err;
            reg_rdata[ST_ADDERR] = add_err;
            reg_rdata[ST_STOP]   = stopped;
            reg_rdata[ST_LARGE]  = large_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R11: a size write while running leaves the stored size alone
   a_r11_busy_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && ra == RA_SIZE && !stopped) |=> $stable(size_q));

   // R9: an unknown format code never changes the mode
   a_r9_bad_fmt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && ra == RA_DFMT && !fmt_ok) |=> $stable(large_q));

   // R10: the effective size is never zero nor above the mode cap
   a_r10_size_range: assert property (@(posedge clk) disable iff (!rst_n)
      (size_eff != '0) && (size_eff <= cap));

endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
   import desc_ring_pkg::*;
#(
   parameter int IDX_W      = 13,
   parameter int CAP_LARGE  = 4096,
   parameter int CAP_SMALL  = 8192,
   parameter int RESET_SIZE = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              eng_req,
   output logic [IDX_W-1:0]  eng_idx,
   input  logic              eng_done
);

   localparam int SZ_W   = IDX_W + 1;
   localparam int N_PTRS = 2;

   generate
      if (SZ_W > CNT_W)                 begin : g_chk_cnt  $error("ring index too wide for the count fields"); end
      if (DONE_IDX_LSB + IDX_W > 32)    begin : g_chk_done $error("index field does not fit the done register"); end
      if (CAP_SMALL > 2 ** IDX_W)       begin : g_chk_cs   $error("small-format cap exceeds index range"); end
      if (CAP_LARGE > CAP_SMALL)        begin : g_chk_cl   $error("large-format cap above small-format cap"); end
      if (RESET_SIZE < 1 || RESET_SIZE > CAP_LARGE) begin : g_chk_rs $error("reset size out of range"); end
   endgenerate

   logic [SZ_W-1:0]  size_eff;
   logic             stopped, clr, add_we, rel_we;
   logic [CNT_W-1:0] avail, pend;
   logic             add_err, rel_err, done_acc;
   logic [SZ_W-1:0]  rel_step;

   logic             ptr_adv  [N_PTRS];
   logic [SZ_W-1:0]  ptr_step [N_PTRS];
   logic [IDX_W-1:0] ptr_val  [N_PTRS];

   ring_regs #(
      .IDX_W(IDX_W), .CAP_LARGE(CAP_LARGE), .CAP_SMALL(CAP_SMALL), .RESET_SIZE(RESET_SIZE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .avail(avail), .pend(pend), .add_err(add_err), .rel_err(rel_err),
      .done_idx(ptr_val[1]),
      .reg_rdata(reg_rdata), .size_eff(size_eff), .stopped(stopped),
      .clr(clr), .add_we(add_we), .rel_we(rel_we)
   );

   ring_counts #(.IDX_W(IDX_W)) u_counts (
      .clk(clk), .rst_n(rst_n), .clr(clr), .size(size_eff),
      .add_we(add_we), .add_n(reg_wdata),
      .rel_we(rel_we), .rel_n(reg_wdata),
      .done_in(eng_done),
      .avail(avail), .pend(pend), .add_err(add_err), .rel_err(rel_err),
      .done_acc(done_acc), .rel_step(rel_step)
   );

   // pointer 0 follows the engine, pointer 1 follows software releases
   assign ptr_adv[0]  = done_acc;
   assign ptr_step[0] = SZ_W'(1);
   assign ptr_adv[1]  = rel_we;
   assign ptr_step[1] = rel_step;

   generate
      for (genvar g = 0; g < N_PTRS; g++) begin : g_ptr
         ring_ptr #(.IDX_W(IDX_W)) u_ptr (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .adv(ptr_adv[g]), .step(ptr_step[g]), .size(size_eff),
            .ptr(ptr_val[g])
         );
      end
   endgenerate

   assign eng_idx = ptr_val[0];
   assign eng_req = !stopped && (avail != '0);

   // R8: a halt write drops the request on the next cycle
   a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'(RA_STOP) && reg_wdata[0]) |=> !eng_req);

   // R4: the offered index holds while no completion is seen
   a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done && !clr) |=> $stable(eng_idx));

endmodule

// File: tb/tb_desc_ring_tracker.sv
`timescale 1ns/1ps
module tb_desc_ring_tracker;

   localparam int IDX_W = 4;
   localparam int CAPL  = 8;
   localparam int CAPS  = 16;
   localparam int RSZ   = 6;
   localparam int A_SIZE = 0, A_FMT = 1, A_ADD = 2, A_REL = 3, A_DONE = 4, A_STOP = 5, A_STAT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic eng_req;
   logic [IDX_W-1:0] eng_idx;
   logic eng_done = 1'b0;

   int n_tests = 0, n_fail = 0;

   // reference state
   int m_avail, m_pend, m_fetch, m_didx, m_size_q;
   bit m_large, m_stop, m_adderr, m_relerr;

   always #2.5 clk = ~clk;

   desc_ring_tracker #(.IDX_W(IDX_W), .CAP_LARGE(CAPL), .CAP_SMALL(CAPS), .RESET_SIZE(RSZ)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .eng_req(eng_req), .eng_idx(eng_idx), .eng_done(eng_done)
   );

   function automatic int eff_size();
      int cap = m_large ? CAPL : CAPS;
      return (m_size_q > cap) ? cap : m_size_q;
   endfunction

   task automatic check(input string req, input string what, input longint got, input longint exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      reg_addr = 3'(a);
      #1;
      v = reg_rdata;
   endtask

   // one clock: optional completion pulse and optional register write
   task automatic cyc(input bit d, input int wa, input int wd);
      int sz, room, acc, racc, dacc;
      bit clr;
      @(negedge clk);
      eng_done = d;
      if (wa >= 0) begin
         reg_we = 1'b1; reg_addr = 3'(wa); reg_wdata = 32'(wd);
      end
      @(posedge clk);
      #1;
      eng_done = 1'b0; reg_we = 1'b0;
      // reference update from the requirements, using pre-cycle state
      sz   = eff_size();
      dacc = (d && m_avail > 0) ? 1 : 0;
      acc  = 0; racc = 0; clr = 0;
      if (wa == A_ADD) begin
         room = sz - m_avail - m_pend;
         acc  = (wd > room) ? room : wd;
         if (wd > room) m_adderr = 1;
      end
      if (wa == A_REL) begin
         racc = (wd > m_pend) ? m_pend : wd;
         if (wd > m_pend) m_relerr = 1;
      end
      m_avail = m_avail + acc - dacc;
      m_pend  = m_pend + dacc - racc;
      m_fetch = (m_fetch + dacc) % sz;
      m_didx  = (m_didx + racc) % sz;
      if (wa == A_SIZE && m_stop) begin
         m_size_q = (wd == 0) ? 1 : ((wd > (1 << IDX_W)) ? (1 << IDX_W) : wd);
         clr = 1;
      end
      if (wa == A_FMT && m_stop && (wd == 7 || wd == 1)) begin
         m_large = (wd == 7);
         clr = 1;
      end
      if (clr) begin
         m_avail = 0; m_pend = 0; m_fetch = 0; m_didx = 0;
      end
      if (wa == A_STOP) m_stop = wd[0];
   endtask

   task automatic check_all(input string req);
      logic [31:0] v;
      longint exp_stat;
      rd(A_STAT, v);
      exp_stat = m_avail | (longint'(m_relerr) << 16) | (longint'(m_adderr) << 17)
               | (longint'(m_stop) << 18) | (longint'(m_large) << 19);
      check(req, "status", v, exp_stat);
      rd(A_DONE, v);
      check(req, "done reg", v, m_pend | (m_didx << 16));
      rd(A_SIZE, v);
      check(req, "size", v, eff_size());
      check(req, "eng_req", eng_req, (!m_stop && m_avail > 0));
      check(req, "eng_idx", eng_idx, m_fetch);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      m_avail = 0; m_pend = 0; m_fetch = 0; m_didx = 0; m_size_q = RSZ;
      m_large = 1; m_stop = 1; m_adderr = 0; m_relerr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check_all("R1");
      rd(A_FMT, v);
      check("R1", "format code", v, 7);

      // R8: enable; nothing available so no request
      cyc(0, A_STOP, 0);
      check_all("R8");

      // R2 / R4: add accumulates and raises the request
      cyc(0, A_ADD, 2);
      cyc(0, A_ADD, 1);
      check_all("R2");
      check("R2", "avail after two adds", m_avail, 3);

      // R5: completions advance the engine index
      cyc(1, -1, 0);
      cyc(1, -1, 0);
      check_all("R5");

      // R6 / R7: release one, completed index moves
      cyc(0, A_REL, 1);
      check_all("R6");

      // R12: completion together with an add, and with an over-release
      cyc(1, A_ADD, 2);
      check_all("R12");
      cyc(1, A_REL, 9);
      check_all("R12");
      check("R6", "release error bit", m_relerr, 1);

      // R3: over-large add is clamped
      cyc(0, A_ADD, 20);
      check_all("R3");
      check("R3", "add error bit", m_adderr, 1);

      // R8: halt drops the request, completions still counted
      cyc(0, A_STOP, 1);
      check_all("R8");
      check("R8", "eng_req after halt", eng_req, 0);
      cyc(1, -1, 0);
      check_all("R8");

      // R11: size write while running is ignored
      cyc(0, A_STOP, 0);
      cyc(0, A_SIZE, 3);
      check_all("R11");
      cyc(0, A_FMT, 1);
      check_all("R11");

      // R9 / R10: formats and size clamp while stopped
      cyc(0, A_STOP, 1);
      cyc(0, A_FMT, 1);
      check_all("R9");
      rd(A_FMT, v);
      check("R9", "small format code", v, 1);
      cyc(0, A_SIZE, 100);
      check_all("R10");
      cyc(0, A_ADD, 2);
      cyc(0, A_FMT, 3);
      check_all("R9");
      check("R9", "avail kept after bad code", m_avail, 2);
      cyc(0, A_FMT, 7);
      check_all("R10");
      cyc(0, A_SIZE, 0);
      check_all("R10");

      // sweep: sizes, formats and mixed same-cycle traffic with wrap
      for (int s = 0; s < 6; s++) begin
         int sz_w = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 5 : (s == 3) ? 8 : (s == 4) ? 16 : 11;
         cyc(0, A_STOP, 1);
         cyc(0, A_FMT, (s >= 4) ? 1 : 7);
         cyc(0, A_SIZE, sz_w);
         check_all("R11");
         cyc(0, A_STOP, 0);
         for (int i = 0; i < 120; i++) begin
            bit d = ((i % 3) != 0);
            case (i % 4)
               0: cyc(d, A_ADD, (i * 7) % (sz_w + 3));
               1: cyc(d, A_REL, (i * 5) % (sz_w + 2));
               2: cyc(d, -1, 0);
               default: cyc(d, A_ADD, 1);
            endcase
            check_all("R12");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule